// File: doc/BRIEF.md
# Inter-processor message mailbox

The block is a memory-mapped mailbox that lets several processors hand 32-bit words to one another. It holds a set of small first-in first-out message queues. A processor sends a word by writing the message register of a queue. The receiving processor takes the oldest word out by reading that same register. For each queue, one register reports whether the queue is full and another reports how many words it holds.

Every processor, called a user, has its own interrupt status register, its own enable register and its own interrupt line. Each queue raises two events into every user's status register: a word was accepted, and a read moved the queue out of the full state. Software clears a status bit by writing 1 to it. The block also has a read-only revision register and a soft-reset request. The soft reset empties every queue, clears every status and enable register, and reports completion through a done flag.

Access uses a single-cycle register bus. Read data is combinational from the address in the cycle where the read strobe is high. A read of a message register removes the word at the clock edge that closes that cycle.

Top module: `mbox_hub`

## Requirements
- R1: The register at byte offset 0x000 reads 0x21: major version 2 in bits 7:4 and minor version 1 in bits 3:0.
- R2: Words written to the message register of queue m (offset 0x040 + 4·m) are returned by reads of that same register in the order they were written, and each read removes one word.
- R3: The count register of queue m (0x0C0 + 4·m) reads the number of stored words. The full register of queue m (0x080 + 4·m) reads 1 when the queue holds DEPTH words and 0 otherwise. A queue that is not addressed keeps its count.
- R4: A write to the message register of a full queue is dropped. The count stays at DEPTH and the stored words are unchanged.
- R5: A read of the message register of an empty queue returns 0 and leaves the count at 0.
- R6: Every accepted write to queue m sets bit 2·m of the status register of every user (status of user u at 0x100 + 8·u).
- R7: A read that takes queue m from full to not full sets bit 2·m+1 of every user's status register. A read from a queue that was not full does not set this bit.
- R8: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged.
- R9: The enable register of user u (0x104 + 8·u) reads back what was written. Interrupt line u is high exactly when the bitwise AND of user u's status and enable registers is nonzero.
- R10: Writing a value with bit 1 set to offset 0x010 starts a soft reset. Bit 0 of offset 0x014 reads 0 for exactly SRST_CYCLES cycles after the write and then reads 1. After the soft reset, every queue is empty and every status and enable register is zero. After power-on reset, bit 0 of offset 0x014 reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; a message-register read removes a word at the closing edge |
| bus_addr | input | 9 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle where bus_rd is high |
| irq_o | output | NUM_USERS | One interrupt line per user |

## Verification
A corrupted read or write pointer shows up in the first read after the fault: words come back out of order, or a stale word comes back. A wrong count shows up at once in the count and full registers, and also in a missing or extra not-full event when a full queue is read. A status or enable register that fails to capture an event, or fails to clear, appears on the interrupt line and in the status readback in the cycle after the bus access. A soft-reset sequencer that runs too long or too short changes the number of cycles the done flag reads 0, and the bench counts that number exactly.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned ADDR_W = 9;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_REV  = 9'h000;
  localparam logic [ADDR_W-1:0] OFS_CFG  = 9'h010;
  localparam logic [ADDR_W-1:0] OFS_STAT = 9'h014;

  // Bit positions inside the control and status words
  localparam int unsigned CFG_SRST_BIT = 1;
  localparam int unsigned STAT_DONE_BIT = 0;

  typedef enum logic [3:0] {
    REG_NONE,
    REG_REV,
    REG_CFG,
    REG_STAT,
    REG_MSG,
    REG_FULL,
    REG_CNT,
    REG_IST,
    REG_IEN
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [4:0]  idx;
  } reg_sel_t;
endpackage

// File: rtl/mbox_queue.sv
module mbox_queue #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              push_ok,
  output logic              nf_evt
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, wr_ptr_nxt;
  logic [PTR_W-1:0]  rd_ptr, rd_ptr_nxt;
  logic [CNT_W-1:0]  cnt_nxt;
  logic              pop_ok;
  logic              empty;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push & ~full & ~clr;
  assign pop_ok  = pop & ~empty & ~clr;
  assign nf_evt  = pop_ok & full;
  assign head    = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) bump = '0;
    else                        bump = p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_nxt = wr_ptr;
    rd_ptr_nxt = rd_ptr;
    cnt_nxt    = count;
    if (clr) begin
      wr_ptr_nxt = '0;
      rd_ptr_nxt = '0;
      cnt_nxt    = '0;
    end else begin
      if (push_ok) wr_ptr_nxt = bump(wr_ptr);
      if (pop_ok)  rd_ptr_nxt = bump(rd_ptr);
      if (push_ok && !pop_ok)      cnt_nxt = count + 1'b1;
      else if (pop_ok && !push_ok) cnt_nxt = count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
      count  <= cnt_nxt;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && (wr_ptr == PTR_W'(e))) mem[e] <= wdata;
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> (count == CNT_W'(DEPTH)));

  // R5
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !clr) |=> (count == '0));
endmodule

// File: rtl/mbox_user_irq.sv
module mbox_user_irq #(
  parameter int unsigned NUM_EV = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [NUM_EV-1:0] ev,
  input  logic              st_w1c,
  input  logic              en_wr,
  input  logic [NUM_EV-1:0] wdata,
  output logic [NUM_EV-1:0] status,
  output logic [NUM_EV-1:0] enable,
  output logic              irq
);
  logic [NUM_EV-1:0] status_nxt;
  logic [NUM_EV-1:0] enable_nxt;

  always_comb begin
    status_nxt = status;
    enable_nxt = enable;
    if (clr) begin
      status_nxt = '0;
      enable_nxt = '0;
    end else begin
      if (st_w1c) status_nxt = status & ~wdata;
      status_nxt = status_nxt | ev;
      if (en_wr)  enable_nxt = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= status_nxt;
      enable <= enable_nxt;
    end
  end

  assign irq = |(status & enable);

  // R6 R7
  ev_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ev) && !clr) |=> ((status & $past(ev)) == $past(ev)));

  // R8
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_w1c && !clr && (ev == '0)) |=> (status == ($past(status) & ~$past(wdata))));

  // R10
  clr_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((status == '0) && (enable == '0)));
endmodule

// File: rtl/mbox_srst.sv
module mbox_srst #(
  parameter int unsigned CYCLES = 4,
  localparam int unsigned CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic clr
);
  logic [CW-1:0] cnt, cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (start)        cnt_nxt = CW'(CYCLES);
    else if (cnt != '0) cnt_nxt = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  assign busy = (cnt != '0);
  assign clr  = start | busy;

  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/mbox_hub.sv
module mbox_hub
  import mbox_pkg::*;
#(
  parameter int unsigned NUM_Q       = 4,
  parameter int unsigned DEPTH       = 4,
  parameter int unsigned NUM_USERS   = 4,
  parameter int unsigned SRST_CYCLES = 4,
  parameter int unsigned REV_MAJOR   = 2,
  parameter int unsigned REV_MINOR   = 1,
  localparam int unsigned EV_W  = 2 * NUM_Q,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned QI_W  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int unsigned UI_W  = (NUM_USERS > 1) ? $clog2(NUM_USERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [NUM_USERS-1:0] irq_o
);
  reg_sel_t          sel;
  logic              srst_busy, srst_clr, srst_start;
  logic [DATA_W-1:0] q_head [NUM_Q];
  logic [CNT_W-1:0]  q_cnt  [NUM_Q];
  logic [NUM_Q-1:0]  q_full, q_push_ok, q_nf_evt;
  logic [EV_W-1:0]   ev_vec;
  logic [EV_W-1:0]   u_st [NUM_USERS];
  logic [EV_W-1:0]   u_en [NUM_USERS];
  logic [QI_W-1:0]   qi;
  logic [UI_W-1:0]   ui;

  // Address decode
  always_comb begin
    sel.kind = REG_NONE;
    sel.idx  = '0;
    if (bus_addr[1:0] == 2'b00) begin
      if (bus_addr == OFS_REV)       sel.kind = REG_REV;
      else if (bus_addr == OFS_CFG)  sel.kind = REG_CFG;
      else if (bus_addr == OFS_STAT) sel.kind = REG_STAT;
      else if (bus_addr[8]) begin
        sel.idx  = bus_addr[7:3];
        sel.kind = bus_addr[2] ? REG_IEN : REG_IST;
        if (sel.idx >= 5'(NUM_USERS)) sel.kind = REG_NONE;
      end else if (bus_addr[7:6] != 2'b00) begin
        sel.idx = {1'b0, bus_addr[5:2]};
        case (bus_addr[7:6])
          2'b01:   sel.kind = REG_MSG;
          2'b10:   sel.kind = REG_FULL;
          default: sel.kind = REG_CNT;
        endcase
        if (sel.idx >= 5'(NUM_Q)) sel.kind = REG_NONE;
      end
    end
  end

  assign qi = sel.idx[QI_W-1:0];
  assign ui = sel.idx[UI_W-1:0];
  assign srst_start = bus_wr & (sel.kind == REG_CFG) & bus_wdata[CFG_SRST_BIT];

  mbox_srst #(.CYCLES(SRST_CYCLES)) srst_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (srst_start),
    .busy  (srst_busy),
    .clr   (srst_clr)
  );

  for (genvar m = 0; m < NUM_Q; m++) begin : g_queue
    logic push_m, pop_m;
    assign push_m = bus_wr & (sel.kind == REG_MSG) & (qi == QI_W'(m));
    assign pop_m  = bus_rd & (sel.kind == REG_MSG) & (qi == QI_W'(m));

    mbox_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) queue_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (srst_clr),
      .push    (push_m),
      .pop     (pop_m),
      .wdata   (bus_wdata),
      .head    (q_head[m]),
      .count   (q_cnt[m]),
      .full    (q_full[m]),
      .push_ok (q_push_ok[m]),
      .nf_evt  (q_nf_evt[m])
    );

    assign ev_vec[2*m]   = q_push_ok[m];
    assign ev_vec[2*m+1] = q_nf_evt[m];
  end

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
    logic w1c_u, enw_u;
    assign w1c_u = bus_wr & (sel.kind == REG_IST) & (ui == UI_W'(u));
    assign enw_u = bus_wr & (sel.kind == REG_IEN) & (ui == UI_W'(u));

    mbox_user_irq #(.NUM_EV(EV_W)) user_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (srst_clr),
      .ev     (ev_vec),
      .st_w1c (w1c_u),
      .en_wr  (enw_u),
      .wdata  (bus_wdata[EV_W-1:0]),
      .status (u_st[u]),
      .enable (u_en[u]),
      .irq    (irq_o[u])
    );
  end

  // Read data
  always_comb begin
    bus_rdata = '0;
    case (sel.kind)
      REG_REV:  bus_rdata = {24'b0, 4'(REV_MAJOR), 4'(REV_MINOR)};
      REG_CFG:  bus_rdata[CFG_SRST_BIT] = srst_busy;
      REG_STAT: bus_rdata[STAT_DONE_BIT] = ~srst_busy;
      REG_MSG:  bus_rdata = (q_cnt[qi] != '0) ? q_head[qi] : '0;
      REG_FULL: bus_rdata[0] = q_full[qi];
      REG_CNT:  bus_rdata = DATA_W'(q_cnt[qi]);
      REG_IST:  bus_rdata = DATA_W'(u_st[ui]);
      REG_IEN:  bus_rdata = DATA_W'(u_en[ui]);
      default:  bus_rdata = '0;
    endcase
  end

  // R7
  nf_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|q_nf_evt) |-> ((q_nf_evt & q_full) == q_nf_evt));
endmodule

// File: tb/mbox_hub_tb_top.sv
module mbox_hub_tb_top;
  localparam int NQ = 4;
  localparam int NU = 4;
  localparam int DEPTH = 4;
  localparam int SRST = 4;

  logic        clk;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [8:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [NU-1:0] irq_o;

  int total;
  int bad;

  mbox_hub #(.NUM_Q(NQ), .DEPTH(DEPTH), .NUM_USERS(NU), .SRST_CYCLES(SRST)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [8:0] a_msg(int m);  return 9'(12'h040 + 4*m); endfunction
  function automatic logic [8:0] a_full(int m); return 9'(12'h080 + 4*m); endfunction
  function automatic logic [8:0] a_cnt(int m);  return 9'(12'h0C0 + 4*m); endfunction
  function automatic logic [8:0] a_ist(int u);  return 9'(12'h100 + 8*u); endfunction
  function automatic logic [8:0] a_ien(int u);  return 9'(12'h104 + 8*u); endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic clear_status();
    for (int u = 0; u < NU; u++) wr(a_ist(u), 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(9'h000, d);  check("R1 revision", d, 32'h21);
    rd(9'h014, d);  check("R10 done after power-on", d, 32'h1);
    rd(a_cnt(0), d); check("R3 count at reset", d, 0);
    rd(a_ist(2), d); check("R6 status at reset", d, 0);
    check("R9 irq at reset", 32'(irq_o), 0);
  endtask

  task automatic t_fifo_order();
    logic [31:0] d;
    wr(a_msg(1), 32'hA1A1_0001);
    wr(a_msg(1), 32'hB2B2_0002);
    wr(a_msg(1), 32'hC3C3_0003);
    rd(a_cnt(1), d);  check("R3 count three", d, 3);
    rd(a_full(1), d); check("R3 not full at three", d, 0);
    rd(a_cnt(0), d);  check("R3 other queue untouched", d, 0);
    rd(a_msg(1), d);  check("R2 first word", d, 32'hA1A1_0001);
    rd(a_msg(1), d);  check("R2 second word", d, 32'hB2B2_0002);
    rd(a_msg(1), d);  check("R2 third word", d, 32'hC3C3_0003);
    rd(a_cnt(1), d);  check("R3 drained", d, 0);
  endtask

  task automatic t_full_drop();
    logic [31:0] d;
    for (int i = 0; i < DEPTH; i++) wr(a_msg(2), 32'h5500 + 32'(i));
    rd(a_full(2), d); check("R3 full flag", d, 1);
    wr(a_msg(2), 32'hDEAD_BEEF);
    rd(a_cnt(2), d);  check("R4 count after dropped write", d, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      rd(a_msg(2), d); check("R4 stored words intact", d, 32'h5500 + 32'(i));
    end
    rd(a_cnt(2), d);  check("R4 nothing extra", d, 0);
  endtask

  task automatic t_empty_pop();
    logic [31:0] d;
    rd(a_msg(3), d); check("R5 empty read value", d, 0);
    rd(a_cnt(3), d); check("R5 empty count", d, 0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    clear_status();
    wr(a_msg(0), 32'h1234);
    for (int u = 0; u < NU; u++) begin
      rd(a_ist(u), d); check("R6 new-message bit every user", d, 32'h1);
    end
    check("R9 no irq without enable", 32'(irq_o), 0);
    wr(a_ien(1), 32'h1);
    rd(a_ien(1), d); check("R9 enable readback", d, 32'h1);
    check("R9 irq user1", 32'(irq_o), 32'h2);
    wr(a_ist(1), 32'h0);
    rd(a_ist(1), d); check("R8 zero write keeps bit", d, 32'h1);
    wr(a_ist(1), 32'h1);
    rd(a_ist(1), d); check("R8 one write clears bit", d, 32'h0);
    check("R9 irq drops after clear", 32'(irq_o), 0);
    rd(a_ist(0), d); check("R8 other user unaffected", d, 32'h1);
    wr(a_ien(1), 32'h0);
    rd(a_msg(0), d);
  endtask

  task automatic t_notfull();
    logic [31:0] d;
    for (int i = 0; i < DEPTH; i++) wr(a_msg(3), 32'(i));
    clear_status();
    rd(a_msg(3), d);
    rd(a_ist(2), d); check("R7 not-full bit on full-to-not-full", d, 32'h80);
    wr(a_ist(2), 32'h80);
    rd(a_msg(3), d);
    rd(a_ist(2), d); check("R7 no not-full bit from non-full read", d, 32'h0);
    wr(a_ien(3), 32'h80);
    wr(a_msg(3), 32'h9);
    wr(a_msg(3), 32'hA);
    clear_status();
    rd(a_msg(3), d);
    check("R9 irq user3 on not-full event", 32'(irq_o), 32'h8);
    for (int i = 0; i < DEPTH - 1; i++) rd(a_msg(3), d);
  endtask

  task automatic t_srst();
    logic [31:0] d;
    int zeros;
    wr(a_msg(0), 32'h77);
    wr(a_ien(0), 32'hFF);
    check("R9 irq before soft reset", 32'(irq_o[0]), 1);
    wr(9'h010, 32'h2);
    zeros = 0;
    for (int k = 0; k < SRST + 3; k++) begin
      rd(9'h014, d);
      if (d[0] == 1'b0) zeros++;
    end
    check("R10 done low cycles", zeros, SRST);
    rd(9'h014, d);   check("R10 done set", d, 1);
    rd(a_cnt(0), d); check("R10 queue emptied", d, 0);
    rd(a_ien(0), d); check("R10 enable cleared", d, 0);
    rd(a_ist(0), d); check("R10 status cleared", d, 0);
    check("R10 irq low", 32'(irq_o), 0);
  endtask

  initial begin
    total = 0; bad = 0;
    bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_fifo_order();
    t_full_drop();
    t_empty_pop();
    t_irq();
    t_notfull();
    t_srst();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule